// File: doc/BRIEF.md
# Ring-Fed DMA Packet Engine

This block pulls 32-bit command words out of a circular buffer in memory and carries out the DMA packets they encode. Software programs the ring base, the ring size and the enable through a small register port. It then publishes new work by moving the write pointer. The engine reads one word at a time from base plus read pointer and advances the read pointer with wrap-around. Each time a packet is complete, the engine runs it through a single request/acknowledge memory master.

Five packet kinds exist: a block copy, a single-word fence write, a byte-swapped constant fill, a trap that raises an interrupt flag, and a no-op. An optional write-back stores the final read pointer at a programmed address once the ring is empty. Software therefore learns how far the engine got without reading a register.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset, every readable register except status reads 0, irq_o is low and mem_req_o is low.
- R2: The register select on reg_addr_i is 0 control, 1 base, 2 read pointer, 3 write pointer, 4 write-back address, 5 status and 6 trap flag. The base register stores the written value shifted left by 8 and reads back shifted right by 8. The status register always reads 1.
- R3: The packet opcode is header bits [31:28]. Copy is 4'h3 and 5 words long, fence is 4'h6 and 4 words, constant fill is 4'hD and 4 words, trap is 4'h7 and 1 word, and no-op is 4'hF and 1 word. Any other opcode is consumed as a one-word no-op.
- R4: Copy moves header[15:0] words from the source address in word 2 to the destination address in word 1, stepping 4 bytes per word. A count of 0 moves nothing.
- R5: Fence writes word 3 to the address held in word 1.
- R6: Constant fill writes the byte-reversed value of word 2 to header[15:0] consecutive words, starting at the address in word 1.
- R7: Trap sets a flag that reading register 6 returns and clears. irq_o equals that flag gated by control bit 0.
- R8: The ring size in bytes is 4 << control[5:1]. The read pointer is a byte offset that advances by 4, modulo the ring size, for every word fetched from base plus read pointer.
- R9: A write to the write-pointer or control register starts draining only if control bit 0 is set after the write. Draining fetches until the read pointer equals the write pointer. A packet left unfinished continues on a later drain.
- R10: With control bit 12 set, the final read pointer is written to the write-back address after each drain.
- R11: Register writes made during a drain take effect before the next fetch. A write-pointer update during a drain extends that drain. A software write to the read pointer overrides an engine advance in the same cycle.
- R12: While mem_req_o is high and mem_ack_i is low, the next cycle keeps mem_req_o high and mem_addr_o and mem_we_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the trap flag on select 6) |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Trap interrupt, gated by ring enable |

## Verification
Two things can happen in the same cycle here. Software may update a register, and the engine may fetch a word or advance the read pointer on that exact cycle. The bench provokes this by writing the write pointer a second time one cycle after a kick, while the first fetch is still outstanding. It judges the result by whether both fence packets land in memory and the read pointer settles on the second value. A near-exhaustive sweep covers copy and fill lengths 0 to 3 across a ring wrap, and it checks that the word just past each run stays untouched.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_BASE   = 3'd1,
    REG_RPTR   = 3'd2,
    REG_WPTR   = 3'd3,
    REG_WBADDR = 3'd4,
    REG_STATUS = 3'd5,
    REG_TRAP   = 3'd6
  } reg_sel_e;

  localparam logic [3:0] OP_COPY  = 4'h3;
  localparam logic [3:0] OP_FENCE = 4'h6;
  localparam logic [3:0] OP_TRAP  = 4'h7;
  localparam logic [3:0] OP_FILL  = 4'hD;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DISPATCH, S_COPY_RD, S_COPY_WR, S_WRITE, S_WB
  } seq_state_e;

  function automatic logic [2:0] pkt_len(input logic [3:0] op);
    case (op)
      OP_COPY:          pkt_len = 3'd5;
      OP_FENCE, OP_FILL: pkt_len = 3'd4;
      default:          pkt_len = 3'd1;
    endcase
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] x);
    swap32 = {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int DW = 32,
  parameter int BASE_SHIFT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          rptr_adv_i,
  input  logic          trap_set_i,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] rptr_o,
  output logic [DW-1:0] wptr_o,
  output logic [DW-1:0] wb_addr_o,
  output logic          en_o,
  output logic          wb_en_o,
  output logic          kick_o,
  output logic          irq_o
);
  localparam int SZ_LSB = 1;
  localparam int SZ_MSB = 5;
  localparam int WB_BIT = 12;

  logic [DW-1:0] ctrl_q, base_q, rptr_q, wptr_q, wb_q;
  logic          trap_q, kick_q;
  logic [DW-1:0] mask;
  logic          sw_rptr;

  assign mask    = (DW'(4) << ctrl_q[SZ_MSB:SZ_LSB]) - DW'(1);
  assign sw_rptr = reg_we_i && reg_addr_i == REG_RPTR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; base_q <= '0; rptr_q <= '0; wptr_q <= '0; wb_q <= '0;
      trap_q <= 1'b0; kick_q <= 1'b0;
    end else begin
      kick_q <= reg_we_i && (reg_addr_i == REG_WPTR || reg_addr_i == REG_CTRL);
      if (reg_we_i) begin
        case (reg_addr_i)
          REG_CTRL:   ctrl_q <= reg_wdata_i;
          REG_BASE:   base_q <= reg_wdata_i << BASE_SHIFT;
          REG_WPTR:   wptr_q <= reg_wdata_i;
          REG_WBADDR: wb_q   <= reg_wdata_i;
          default: ;
        endcase
      end
      if (sw_rptr)         rptr_q <= reg_wdata_i;
      else if (rptr_adv_i) rptr_q <= (rptr_q + DW'(4)) & mask;
      if (trap_set_i) trap_q <= 1'b1;
      else if (reg_re_i && reg_addr_i == REG_TRAP) trap_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      REG_CTRL:   reg_rdata_o = ctrl_q;
      REG_BASE:   reg_rdata_o = base_q >> BASE_SHIFT;
      REG_RPTR:   reg_rdata_o = rptr_q;
      REG_WPTR:   reg_rdata_o = wptr_q;
      REG_WBADDR: reg_rdata_o = wb_q;
      REG_STATUS: reg_rdata_o = DW'(1);
      REG_TRAP:   reg_rdata_o = DW'(trap_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign base_o    = base_q;
  assign rptr_o    = rptr_q;
  assign wptr_o    = wptr_q;
  assign wb_addr_o = wb_q;
  assign en_o      = ctrl_q[0];
  assign wb_en_o   = ctrl_q[WB_BIT];
  assign kick_o    = kick_q;
  assign irq_o     = trap_q & ctrl_q[0];

  // R8: an engine advance leaves the pointer inside the ring
  a_r8_rptr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_adv_i && !sw_rptr |=> (rptr_q & ~$past(mask)) == '0);
  // R7: reading the flag clears it unless a trap lands in the same cycle
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i && reg_addr_i == REG_TRAP && !trap_set_i |=> !irq_o);
endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
  import dma_ring_pkg::*;
#(
  parameter int DW  = 32,
  parameter int CNT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic          en_i,
  input  logic          wb_en_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] rptr_i,
  input  logic [DW-1:0] wptr_i,
  input  logic [DW-1:0] wb_addr_i,
  output logic          rptr_adv_o,
  output logic          trap_set_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  seq_state_e    st;
  logic          draining;
  logic [2:0]    idx, len;
  logic [3:0]    op_q;
  logic [CNT-1:0] hcnt_q, cnt, total_q;
  logic [DW-1:0] a1, a2, a3, addr_q, data_q;
  logic [DW-1:0] off;
  logic [3:0]    w_op;

  assign off  = DW'({cnt, 2'b00});
  assign w_op = mem_rdata_i[31:28];

  assign mem_req_o  = st inside {S_FETCH, S_COPY_RD, S_COPY_WR, S_WRITE, S_WB};
  assign mem_we_o   = st inside {S_COPY_WR, S_WRITE, S_WB};
  assign rptr_adv_o = st == S_FETCH && mem_ack_i;
  assign trap_set_o = rptr_adv_o && idx == 3'd0 && w_op == OP_TRAP;

  always_comb begin
    case (st)
      S_COPY_RD:          mem_addr_o = a2 + off;
      S_COPY_WR, S_WRITE: mem_addr_o = a1 + off;
      default:            mem_addr_o = addr_q;
    endcase
    mem_wdata_o = mem_we_o ? data_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; draining <= 1'b0; idx <= '0; len <= '0; op_q <= '0;
      hcnt_q <= '0; cnt <= '0; total_q <= '0;
      a1 <= '0; a2 <= '0; a3 <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (draining) begin
          if (!en_i) draining <= 1'b0;
          else if (rptr_i != wptr_i) begin
            addr_q <= base_i + rptr_i;
            st     <= S_FETCH;
          end else if (wb_en_i) begin
            addr_q <= wb_addr_i;
            data_q <= rptr_i;
            st     <= S_WB;
          end else draining <= 1'b0;
        end
        S_FETCH: if (mem_ack_i) begin
          st <= S_IDLE;
          if (idx == 3'd0) begin
            op_q   <= w_op;
            hcnt_q <= mem_rdata_i[CNT-1:0];
            len    <= pkt_len(w_op);
            if (pkt_len(w_op) != 3'd1) idx <= 3'd1;
          end else begin
            case (idx)
              3'd1: a1 <= mem_rdata_i;
              3'd2: a2 <= mem_rdata_i;
              3'd3: a3 <= mem_rdata_i;
              default: ;
            endcase
            if (idx + 3'd1 == len) begin
              idx <= '0;
              st  <= S_DISPATCH;
            end else idx <= idx + 3'd1;
          end
        end
        S_DISPATCH: begin
          cnt <= '0;
          st  <= S_IDLE;
          case (op_q)
            OP_COPY:  if (hcnt_q != '0) st <= S_COPY_RD;
            OP_FENCE: begin data_q <= a3; total_q <= CNT'(1); st <= S_WRITE; end
            OP_FILL:  if (hcnt_q != '0) begin
              data_q <= swap32(a2); total_q <= hcnt_q; st <= S_WRITE;
            end
            default: ;
          endcase
        end
        S_COPY_RD: if (mem_ack_i) begin data_q <= mem_rdata_i; st <= S_COPY_WR; end
        S_COPY_WR: if (mem_ack_i) begin
          if (cnt + CNT'(1) == hcnt_q) st <= S_IDLE;
          else begin cnt <= cnt + CNT'(1); st <= S_COPY_RD; end
        end
        S_WRITE: if (mem_ack_i) begin
          if (cnt + CNT'(1) == total_q) st <= S_IDLE;
          else cnt <= cnt + CNT'(1);
        end
        S_WB: if (mem_ack_i) begin
          st <= S_IDLE;
          if (rptr_i == wptr_i) draining <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
      if (kick_i && en_i) draining <= 1'b1;
    end
  end

  // R12: a pending request holds its address and direction
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R9: a fetch only starts from an enabled ring
  a_r9_fetch_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == S_FETCH && $past(st) == S_IDLE |-> $past(en_i));
  // R7: the trap flag is only raised by a fetched header word
  a_r7_trap_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_set_o |-> mem_req_o && !mem_we_o && mem_ack_i);
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          irq_o
);
  logic          rptr_adv, trap_set, en, wb_en, kick;
  logic [DW-1:0] base, rptr, wptr, wb_addr;

  dma_ring_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rptr_adv_i(rptr_adv), .trap_set_i(trap_set),
    .base_o(base), .rptr_o(rptr), .wptr_o(wptr), .wb_addr_o(wb_addr),
    .en_o(en), .wb_en_o(wb_en), .kick_o(kick), .irq_o
  );

  dma_ring_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni, .kick_i(kick), .en_i(en), .wb_en_i(wb_en),
    .base_i(base), .rptr_i(rptr), .wptr_i(wptr), .wb_addr_i(wb_addr),
    .rptr_adv_o(rptr_adv), .trap_set_o(trap_set),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  // R7: interrupt never shows while the ring is disabled
  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en);
endmodule

// File: tb/dma_ring_engine_test.sv
module dma_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING = 32'h100;

  logic        clk = 0, rst_n = 0;
  logic        we = 0, re = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        mem_req, mem_we, mem_ack = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] mem [256];
  int tests = 0, fails = 0, wp = 0, hold_err = 0;
  logic        prev_pend = 0;
  logic [31:0] prev_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ring_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
    end else mem_ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_err++;
    prev_pend = mem_req && !mem_ack;
    prev_addr = mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic put(input logic [31:0] w);
    mem[(RING + 32'(wp)) >> 2] = w;
    wp = (wp + 4) % 64;
  endtask

  task automatic run();
    reg_wr(3, 32'(wp));
    repeat (200) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin reg_rd(3'(a), d); chk("R1 reg", d, 0); end
    reg_rd(6, d); chk("R1 trap", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 req", {31'b0, mem_req}, 0);
    // R2 base and status
    reg_rd(5, d); chk("R2 status", d, 1);
    reg_wr(1, 32'hABCDEF12); reg_rd(1, d); chk("R2 base", d, 32'h00CDEF12);
    reg_wr(1, 32'h1); reg_rd(1, d); chk("R2 base", d, 1);
    reg_wr(0, 32'h9);  // enable, 64-byte ring
    // R5 fence
    put(32'h6000_0000); put(32'h300); put(0); put(32'hCAFE0001);
    run();
    chk("R5 fence", mem[32'h300 >> 2], 32'hCAFE0001);
    reg_rd(2, d); chk("R9 rptr", d, 32'(wp));
    // R4 copy sweep with R8 wrap
    for (int k = 0; k < 4; k++) mem[(32'h200 >> 2) + k] = 32'h1000 + 32'(k);
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 5; k++) mem[(32'h380 >> 2) + k] = 0;
      put(32'h3000_0000 | 32'(n)); put(32'h380); put(32'h200); put(0); put(0);
      run();
      for (int k = 0; k <= n; k++)
        chk("R4 copy", mem[(32'h380 >> 2) + k], (k < n) ? 32'h1000 + 32'(k) : 0);
      reg_rd(2, d); chk("R8 rptr wrap", d, 32'(wp));
    end
    // R6 fill sweep
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 5; k++) mem[(32'h340 >> 2) + k] = 0;
      put(32'hD000_0000 | 32'(n)); put(32'h340); put(32'h11223344); put(0);
      run();
      for (int k = 0; k <= n; k++)
        chk("R6 fill", mem[(32'h340 >> 2) + k], (k < n) ? 32'h44332211 : 0);
    end
    // R7 trap and gating
    put(32'h7000_0000); run();
    chk("R7 irq set", {31'b0, irq}, 1);
    reg_wr(0, 32'h8); chk("R7 irq gated", {31'b0, irq}, 0);
    reg_wr(0, 32'h9); repeat (5) @(negedge clk);
    chk("R7 irq back", {31'b0, irq}, 1);
    reg_rd(6, d); chk("R7 flag", d, 1);
    chk("R7 cleared", {31'b0, irq}, 0);
    reg_rd(6, d); chk("R7 flag clr", d, 0);
    // R9 disabled ring ignores the kick
    reg_wr(0, 32'h8);
    reg_rd(2, d);
    begin
      logic [31:0] r0;
      r0 = d;
      put(32'h6000_0000); put(32'h304); put(0); put(32'hD15AB1ED);
      run();
      reg_rd(2, d); chk("R9 no drain", d, r0);
      chk("R9 no write", mem[32'h304 >> 2], 0);
    end
    reg_wr(0, 32'h9); repeat (200) @(negedge clk);
    chk("R9 ctrl kick", mem[32'h304 >> 2], 32'hD15AB1ED);
    // R3 unknown opcode is a one-word no-op
    put(32'h1234_5678); put(32'h6000_0000); put(32'h308); put(0); put(32'h5555AAAA);
    run();
    chk("R3 unknown op", mem[32'h308 >> 2], 32'h5555AAAA);
    reg_rd(2, d); chk("R3 rptr", d, 32'(wp));
    // R10 write-back of read pointer
    reg_wr(4, 32'h3F0); reg_wr(0, 32'h1009);
    put(32'hF000_0000); run();
    chk("R10 writeback", mem[32'h3F0 >> 2], 32'(wp));
    reg_wr(0, 32'h9);
    // R11 write-pointer update during a drain
    begin
      int mid;
      put(32'h6000_0000); put(32'h310); put(0); put(32'hA1);
      mid = wp;
      put(32'h6000_0000); put(32'h314); put(0); put(32'hB2);
      @(negedge clk); we = 1; addr = 3; wdata = 32'(mid);
      @(negedge clk); wdata = 32'(wp);
      @(negedge clk); we = 0;
      repeat (200) @(negedge clk);
      chk("R11 first", mem[32'h310 >> 2], 32'hA1);
      chk("R11 second", mem[32'h314 >> 2], 32'hB2);
      reg_rd(2, d); chk("R11 rptr", d, 32'(wp));
    end
    // R11 software read-pointer write
    reg_wr(0, 32'h8); reg_wr(2, 32'h24); reg_rd(2, d); chk("R11 sw rptr", d, 32'h24);
    chk("R12 req hold", 32'(hold_err), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule